// File: doc/BRIEF.md
# Reed-Solomon Syndrome Generator with Error Detection

This block sits at the front of a Reed-Solomon decoder for 255-symbol codewords with 239 data symbols and 16 check symbols over GF(2^8). It takes one received byte per clock. For each of the 16 roots alpha^1 to alpha^16 it evaluates the received polynomial in a serial Horner chain, so that all syndromes are ready as soon as the last byte has gone in.

It processes every codeword. When a codeword ends, the block registers all 16 syndromes, pulses a completion strobe and drives a registered flag that tells whether any syndrome is nonzero. A separate key-equation solver uses that flag as its only wake-up signal, so the solver stays idle while codewords arrive clean.

Codewords can follow each other with no gap. The next word builds up in the working registers while the published results stay in their own output registers.

Top module: `rs_syndrome_detector`

## Requirements
- R1: When a codeword completes, syndrome S_j (j = 1..16) appears on `syn_out[8*(j-1) +: 8]` and equals the sum over k = 0..254 of r_k·alpha^(j·(254−k)). Here r_k is the k-th accepted byte, so the first byte is the highest-degree coefficient. The arithmetic is in GF(2^8) with field polynomial x^8+x^4+x^3+x^2+1 (0x11D) and alpha = 0x02.
- R2: A byte is taken only in a cycle where `in_valid` is high. Cycles where `in_valid` is low do not advance the codeword and do not change the syndromes it accumulates.
- R3: `syn_done` goes high for exactly one cycle: the cycle right after the clock edge that accepts the 255th byte of a codeword.
- R4: `err_detected` is valid while `syn_done` is high. It is 1 if and only if at least one of the 16 syndromes is nonzero, so a valid codeword gives 0.
- R5: `syn_out` and `err_detected` keep their values from one `syn_done` pulse to the next.
- R6: A byte with `in_valid` and `in_start` both high always begins a new codeword. Any partial codeword in progress is dropped.
- R7: Bytes with `in_valid` high are ignored when no codeword is open, meaning before any start or after the 255th byte, and they carry no `in_start`. They neither produce a `syn_done` nor change the outputs.
- R8: A new codeword may start in the cycle right after the previous 255th byte. Both codewords still yield correct results.
- R9: After reset, `syn_done` and `err_detected` are 0 and all of `syn_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte qualifier |
| in_start | input | 1 | Marks the first byte of a codeword |
| in_sym | input | 8 | Received byte |
| syn_out | output | 128 | The 16 syndromes, S_1 in the low byte |
| syn_done | output | 1 | One-cycle completion strobe |
| err_detected | output | 1 | Some syndrome is nonzero (solver wake-up) |

## Verification
The results depend on one register stage past the accepting edge. The syndromes, the completion strobe and the error flag all belong to the cycle after the 255th byte is accepted. The bench drives inputs on the falling edge and notes the cycle count when it drives each final byte. It then expects the strobe, with the matching syndromes and flag, exactly one cycle later. Any strobe that turns up without such an expectation is counted as a failure, and in the ignored-input and gap cases the held outputs are compared several cycles after the stimulus.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

    parameter int SYM_W  = 8;
    parameter int NSYN   = 16;
    parameter int CW_LEN = 255;
    parameter logic [SYM_W:0] FIELD_POLY = 9'h11D;

    localparam int CNT_W = $clog2(CW_LEN + 1);

    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        logic valid;
        logic start;
        sym_t data;
    } sym_in_t;

    typedef struct packed {
        logic take;   // byte accepted this cycle
        logic first;  // byte opens a codeword
        logic last;   // byte closes a codeword
    } step_t;

    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t p;
        sym_t x;
        p = '0;
        x = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) p = p ^ x;
            x = x[SYM_W-1] ? ((x << 1) ^ FIELD_POLY[SYM_W-1:0]) : (x << 1);
        end
        return p;
    endfunction

    function automatic sym_t alpha_pow(input int e);
        sym_t r;
        r = sym_t'(1);
        for (int i = 0; i < e; i++) r = gf_mul(r, sym_t'(2));
        return r;
    endfunction

endpackage

// File: rtl/rs_syn_ctrl.sv
module rs_syn_ctrl
    import rs_syn_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sym_in_t sin,
    output step_t   step
);
    logic [CNT_W-1:0] cnt;      // bytes taken so far; 0 means no codeword open
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        step.first = sin.valid && sin.start;
        step.take  = sin.valid && (sin.start || (cnt != '0));
        cnt_nxt    = step.first ? CNT_W'(1) : cnt + CNT_W'(1);
        step.last  = step.take && (cnt_nxt == CNT_W'(CW_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (step.take) begin
            cnt <= step.last ? '0 : cnt_nxt;
        end
    end
endmodule

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
    import rs_syn_pkg::*;
#(
    parameter int ROOT = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  step_t step,
    input  sym_t  sym,
    output sym_t  nxt
);
    localparam sym_t ROOT_K = alpha_pow(ROOT);

    sym_t acc;

    always_comb begin
        nxt = step.first ? sym : (gf_mul(acc, ROOT_K) ^ sym);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (step.take) begin
            acc <= nxt;
        end
    end
endmodule

// File: rtl/rs_syn_publish.sv
module rs_syn_publish
    import rs_syn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  last,
    input  logic [NSYN*SYM_W-1:0] nxt_all,
    output logic [NSYN*SYM_W-1:0] syn_q,
    output logic                  done_q,
    output logic                  err_q
);
    logic [NSYN-1:0] nz;

    generate
        for (genvar j = 0; j < NSYN; j++) begin : g_nz
            assign nz[j] = |nxt_all[j*SYM_W +: SYM_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            syn_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= last;
            if (last) begin
                syn_q <= nxt_all;
                err_q <= |nz;
            end
        end
    end
endmodule

// File: rtl/rs_syndrome_detector.sv
module rs_syndrome_detector
    import rs_syn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_start,
    input  logic [SYM_W-1:0]      in_sym,
    output logic [NSYN*SYM_W-1:0] syn_out,
    output logic                  syn_done,
    output logic                  err_detected
);
    sym_in_t sin;
    step_t   step;
    logic [NSYN*SYM_W-1:0] nxt_all;

    assign sin = '{valid: in_valid, start: in_start, data: in_sym};

    rs_syn_ctrl u_ctrl (
        .clk (clk),
        .rst (rst),
        .sin (sin),
        .step(step)
    );

    generate
        for (genvar j = 0; j < NSYN; j++) begin : g_cell
            rs_syn_cell #(.ROOT(j + 1)) u_cell (
                .clk (clk),
                .rst (rst),
                .step(step),
                .sym (sin.data),
                .nxt (nxt_all[j*SYM_W +: SYM_W])
            );
        end
    endgenerate

    rs_syn_publish u_pub (
        .clk    (clk),
        .rst    (rst),
        .last   (step.last),
        .nxt_all(nxt_all),
        .syn_q  (syn_out),
        .done_q (syn_done),
        .err_q  (err_detected)
    );
endmodule

// File: rtl/rs_syn_checker.sv
module rs_syn_checker
    import rs_syn_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [NSYN*SYM_W-1:0] syn_out,
    input logic                  syn_done,
    input logic                  err_detected
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        syn_done |=> !syn_done); // R3

    AST_DONE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        syn_done |-> $past(in_valid)); // R2

    AST_FLAG_MATCHES: assert property (@(posedge clk) disable iff (rst)
        syn_done |-> (err_detected == (syn_out != '0))); // R4

    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (rst)
        !syn_done |-> ($stable(syn_out) && $stable(err_detected))); // R5

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (!syn_done && !err_detected && (syn_out == '0))); // R9
endmodule

bind rs_syndrome_detector rs_syn_checker u_syn_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .syn_out     (syn_out),
    .syn_done    (syn_done),
    .err_detected(err_detected)
);

// File: tb/test_rs_syndrome_detector.sv
module test_rs_syndrome_detector;
    localparam int CLK_PERIOD = 10;
    localparam int N = 255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_start = 1'b0;
    logic [7:0] in_sym = 8'h00;
    logic [127:0] syn_out;
    logic syn_done;
    logic err_detected;

    rs_syndrome_detector i_rs_syndrome_detector (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_sym(in_sym), .syn_out(syn_out), .syn_done(syn_done),
        .err_detected(err_detected)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    int exp_t [0:254];
    int log_t [0:255];
    int g [0:16];
    int cw [0:N-1];   // cw[i] = coefficient of x^i

    int          q_due [0:7];
    logic [127:0] q_syn [0:7];
    logic        q_err [0:7];
    int q_head = 0;
    int q_tail = 0;
    logic [127:0] last_syn = '0;
    logic         last_err = 1'b0;

    function automatic int gmul(int a, int b);
        if (a == 0 || b == 0) return 0;
        return exp_t[(log_t[a] + log_t[b]) % 255];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic build_tables();
        int x = 1;
        for (int i = 0; i < 255; i++) begin
            exp_t[i] = x;
            log_t[x] = i;
            x = x << 1;
            if (x & 256) x = x ^ 'h11D;
        end
        log_t[0] = 0;
        for (int i = 0; i <= 16; i++) g[i] = 0;
        g[0] = 1;
        for (int j = 1; j <= 16; j++) begin
            for (int i = 16; i >= 0; i--)
                g[i] = (i > 0 ? g[i-1] : 0) ^ gmul(g[i], exp_t[j]);
        end
    endtask

    task automatic make_valid(input bit zero);
        for (int i = 0; i < N; i++) cw[i] = 0;
        if (!zero) begin
            for (int i = 0; i < 239; i++) begin
                int m = $urandom_range(255);
                for (int d = 0; d <= 16; d++) cw[i+d] = cw[i+d] ^ gmul(m, g[d]);
            end
        end
    endtask

    function automatic logic [127:0] ref_syn();
        logic [127:0] s = '0;
        for (int j = 1; j <= 16; j++) begin
            int acc = 0;
            for (int i = 0; i < N; i++)
                if (cw[i] != 0) acc = acc ^ gmul(cw[i], exp_t[(j * i) % 255]);
            s[(j-1)*8 +: 8] = 8'(acc);
        end
        return s;
    endfunction

    // byte k carries cw[254-k]; gaps inserts idle cycles when gap is set
    task automatic send_cw(input bit gap);
        logic [127:0] s = ref_syn();
        for (int k = 0; k < N; k++) begin
            if (gap && (k % 7 == 3)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_start = 1'b0;
                in_sym   = 8'hA5;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (k == 0);
            in_sym   = 8'(cw[N-1-k]);
            if (k == N-1) begin
                q_due[q_tail] = cyc + 1;
                q_syn[q_tail] = s;
                q_err[q_tail] = (s != '0);
                q_tail = (q_tail + 1) % 8;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_start = 1'b0;
        end
    endtask

    // result monitor: every due entry must see its strobe; no stray strobes (R7)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (q_head != q_tail && q_due[q_head] == cyc) begin
                check(syn_done == 1'b1, "R3", "done one cycle after last byte",
                      128'(syn_done), 128'd1);
                check(syn_out == q_syn[q_head], "R1", "syndromes", syn_out, q_syn[q_head]);
                check(err_detected == q_err[q_head], "R4", "error flag",
                      128'(err_detected), 128'(q_err[q_head]));
                last_syn = q_syn[q_head];
                last_err = q_err[q_head];
                q_head = (q_head + 1) % 8;
            end else if (syn_done) begin
                check(1'b0, "R7", "unexpected done", 128'd1, 128'd0);
            end
        end
    end

    initial begin
        build_tables();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(syn_done == 0 && err_detected == 0 && syn_out == '0, "R9",
              "reset state", {syn_out[125:0], syn_done, err_detected}, '0);

        // all-zero and valid codewords: no error (R4)
        make_valid(1'b1); send_cw(1'b0); idle(3);
        for (int t = 0; t < 3; t++) begin make_valid(1'b0); send_cw(1'b0); idle(2); end

        // single errors at edges and middle, one multi-error word (R1)
        make_valid(1'b0); cw[254] = cw[254] ^ 'h01; send_cw(1'b0); idle(2);
        make_valid(1'b0); cw[0]   = cw[0]   ^ 'h80; send_cw(1'b0); idle(2);
        make_valid(1'b0); cw[100] = cw[100] ^ 'h3C; send_cw(1'b0); idle(2);
        make_valid(1'b0);
        for (int e = 0; e < 8; e++) cw[e*31+5] = cw[e*31+5] ^ (e + 1);
        send_cw(1'b0); idle(2);

        // gaps in valid do not disturb accumulation (R2)
        make_valid(1'b0); cw[17] = cw[17] ^ 'hFF; send_cw(1'b1); idle(2);
        make_valid(1'b0); send_cw(1'b1); idle(4);
        check(syn_out == last_syn && err_detected == last_err, "R5",
              "hold after gap word", syn_out, last_syn);

        // stray bytes with no open codeword are ignored (R7)
        make_valid(1'b0); cw[3] = cw[3] ^ 'h11; send_cw(1'b0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); in_valid = 1'b1; in_start = 1'b0; in_sym = 8'(i * 13 + 1);
        end
        idle(5);
        check(syn_out == last_syn, "R7", "syndromes after stray bytes", syn_out, last_syn);
        check(err_detected == last_err, "R5", "flag held", 128'(err_detected), 128'(last_err));

        // restart drops a partial codeword (R6)
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); in_valid = 1'b1; in_start = (i == 0); in_sym = 8'(i + 7);
        end
        make_valid(1'b0); cw[200] = cw[200] ^ 'h42; send_cw(1'b0); idle(3);

        // sweep: single error at every position, back to back (R8)
        for (int p = 0; p < N; p++) begin
            make_valid(1'b0);
            cw[p] = cw[p] ^ ((p % 255) + 1);
            send_cw(1'b0);
        end
        make_valid(1'b0); send_cw(1'b0);
        idle(4);
        check(q_head == q_tail, "R8", "all back-to-back results seen",
              128'(q_tail - q_head), 128'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end
endmodule